// File: doc/BRIEF.md
# Legalising Power-of-Two Clock Divider Bank

This block holds one 16-bit clock-control word that packs six 2-bit divide exponents: CPU, DSP, DSP memory-management unit (MMU), system bus, LCD and peripheral. Each exponent `e` selects a divisor of 2^e from a shared source clock. For each field the block emits a one-cycle clock-enable strobe at the divided rate. A downstream clock gate or a synchronous consumer uses that strobe as a qualified enable.

Software writes the word in two ways. A direct write stores the whole word. A rate request names one field and a target frequency, and the block picks the exponent for that field. In both cases the candidate word passes through a legalising stage before it is stored. That stage keeps the MMU clock tied to the DSP clock within a factor of two. It also holds the bus clock no faster than the CPU and MMU clocks, and no slower than the LCD and peripheral clocks. The stored word is the legalised one, and that is what reads back.

Top module: `ckdiv_bank`

## Requirements
- R1: After reset the control word reads as the legalised `RESET_VAL` (default 0x0000), and every strobe is high in every cycle until the first change.
- R2: Field i sits at bits [2i+1:2i], in the order CPU=0, DSP=1, MMU=2, BUS=3, LCD=4, PER=5. A field value v means divide by 2^v. Bits [15:12] are stored exactly as written.
- R3: A stored MMU exponent is raised to the DSP exponent if it is below it, and lowered to DSP+1 if it is above that.
- R4: The BUS exponent is raised to the larger of the CPU exponent and the clamped MMU exponent.
- R5: After that raise, the BUS exponent is lowered to the smaller of the LCD and PER exponents. This ceiling wins when the two bounds conflict.
- R6: Strobe i is high in the first cycle after its field takes a new value. After that it is high in one cycle out of every 2^field cycles.
- R7: A rate request on field f with target T stores the smallest e in 0..3 for which SRC_RATE/2^e <= T into field f. The resulting word is then legalised.
- R8: A rate request is rejected if no exponent qualifies (T < SRC_RATE/8) or if f > 5. On rejection the word is left unchanged, and `req_reject` is high in the cycle after the request.
- R9: A write and a request in the same cycle store the write. The request is dropped without a reject.
- R10: A store that leaves a field's value unchanged does not disturb that field's strobe phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Direct write strobe |
| wr_data | input | 16 | Word to legalise and store |
| req_valid | input | 1 | Rate request strobe |
| req_field | input | 3 | Field index of the request |
| req_target | input | RATE_W | Requested maximum frequency |
| ctl_rd | output | 16 | Stored, legalised control word |
| req_reject | output | 1 | Last-cycle request was refused |
| div_tick | output | 6 | Per-field divided clock-enable strobes |

## Verification
The assertions check the stored word on every cycle. They confirm that the MMU exponent stays inside its window, that the bus exponent stays under its ceiling and over its effective floor, and that the spare bits follow a write. They also check that a refused request leaves the word untouched, that a write wins over a request, and that a strobe never fires twice in a row on a nonzero divider. Only the bench's scenarios can show the rest: that the exact exponent chosen for a target rate is correct, where the strobe phase lands after a change, and that rewriting an unchanged field keeps its phase.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;
  localparam int REG_W    = 16;
  localparam int FIELD_W  = 2;
  localparam int N_FIELDS = 6;
  localparam int SPARE_LO = N_FIELDS * FIELD_W;

  localparam int F_CPU = 0;
  localparam int F_DSP = 1;
  localparam int F_MMU = 2;
  localparam int F_BUS = 3;
  localparam int F_LCD = 4;
  localparam int F_PER = 5;

  typedef logic [FIELD_W-1:0] exp_t;
  typedef logic [FIELD_W:0]   wexp_t;  // one bit of headroom for DSP+1
  typedef logic [REG_W-1:0]   ctl_t;

  function automatic exp_t get_f(ctl_t v, int idx);
    return v[idx*FIELD_W +: FIELD_W];
  endfunction

  function automatic ctl_t put_f(ctl_t v, int idx, exp_t e);
    ctl_t r;
    r = v;
    r[idx*FIELD_W +: FIELD_W] = e;
    return r;
  endfunction

  function automatic wexp_t wmax(wexp_t a, wexp_t b);
    return (a > b) ? a : b;
  endfunction

  function automatic wexp_t wmin(wexp_t a, wexp_t b);
    return (a < b) ? a : b;
  endfunction

  // Clamp order matters: MMU window, then bus floor, then bus ceiling.
  function automatic ctl_t legalise(ctl_t raw);
    wexp_t cpu, dsp, mmu, bus, lcd, per;
    ctl_t  o;
    cpu = {1'b0, get_f(raw, F_CPU)};
    dsp = {1'b0, get_f(raw, F_DSP)};
    mmu = {1'b0, get_f(raw, F_MMU)};
    bus = {1'b0, get_f(raw, F_BUS)};
    lcd = {1'b0, get_f(raw, F_LCD)};
    per = {1'b0, get_f(raw, F_PER)};
    mmu = wmax(mmu, dsp);
    mmu = wmin(mmu, dsp + wexp_t'(1));
    bus = wmax(bus, cpu);
    bus = wmax(bus, mmu);
    bus = wmin(bus, lcd);
    bus = wmin(bus, per);
    o = put_f(raw, F_MMU, mmu[FIELD_W-1:0]);
    o = put_f(o,   F_BUS, bus[FIELD_W-1:0]);
    return o;
  endfunction
endpackage

// File: rtl/ckdiv_rate_pick.sv
module ckdiv_rate_pick #(
  parameter int unsigned SRC_RATE = 96_000_000,
  parameter int          RATE_W   = 32
) (
  input  logic [RATE_W-1:0] target_i,
  output logic [2:0]        exp_o     // 4 means no exponent qualifies
);
  localparam logic [RATE_W-1:0] SRC = RATE_W'(SRC_RATE);

  // Scan from slowest to fastest so the smallest qualifying exponent wins.
  always_comb begin
    exp_o = 3'd4;
    for (int e = 3; e >= 0; e--) begin
      if ((SRC >> e) <= target_i) exp_o = 3'(e);
    end
  end
endmodule

// File: rtl/ckdiv_strobe.sv
module ckdiv_strobe
  import ckdiv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  exp_t exp_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int CNT_W = (1 << FIELD_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  assign lim    = CNT_W'((1 << exp_i) - 1);
  assign tick_o = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (restart_i)    cnt <= '0;
    else if (cnt >= lim)   cnt <= '0;
    else                   cnt <= cnt + CNT_W'(1);
  end

  // R6: with a divider above one, a pulse is never followed by another pulse
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && exp_i != '0 && !restart_i) |=> !tick_o);
endmodule

// File: rtl/ckdiv_ctlreg.sv
module ckdiv_ctlreg
  import ckdiv_pkg::*;
#(
  parameter logic [15:0] RESET_VAL = 16'h0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  ctl_t                wr_data,
  input  logic                req_valid,
  input  logic [2:0]          req_field,
  input  logic [2:0]          req_exp,
  output ctl_t                ctl_q,
  output logic                reject_q,
  output logic [N_FIELDS-1:0] restart_o
);
  ctl_t ctl_d;
  logic req_take;   // request accepted this cycle
  logic req_refuse; // request refused this cycle

  assign req_take   = req_valid && !wr_en && (int'(req_field) < N_FIELDS) && !req_exp[2];
  assign req_refuse = req_valid && !wr_en && !req_take;

  always_comb begin
    if (wr_en)         ctl_d = legalise(wr_data);
    else if (req_take) ctl_d = legalise(put_f(ctl_q, int'(req_field), req_exp[FIELD_W-1:0]));
    else               ctl_d = ctl_q;
  end

  for (genvar g = 0; g < N_FIELDS; g++) begin : g_restart
    assign restart_o[g] = (get_f(ctl_d, g) != get_f(ctl_q, g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= legalise(RESET_VAL);
      reject_q <= 1'b0;
    end else begin
      ctl_q    <= ctl_d;
      reject_q <= req_refuse;
    end
  end

  // R3: MMU exponent stays within [DSP, DSP+1]
  a_r3_mmu_window: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, get_f(ctl_q, F_MMU)} >= {1'b0, get_f(ctl_q, F_DSP)}) &&
    ({1'b0, get_f(ctl_q, F_MMU)} <= {1'b0, get_f(ctl_q, F_DSP)} + 3'd1));

  // R5: bus exponent never exceeds LCD or PER exponent
  a_r5_bus_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    (get_f(ctl_q, F_BUS) <= get_f(ctl_q, F_LCD)) &&
    (get_f(ctl_q, F_BUS) <= get_f(ctl_q, F_PER)));

  // R4: bus exponent reaches its floor unless the ceiling cuts it
  a_r4_bus_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (get_f(ctl_q, F_BUS) >= get_f(ctl_q, F_CPU) && get_f(ctl_q, F_BUS) >= get_f(ctl_q, F_MMU)) ||
    (get_f(ctl_q, F_BUS) == get_f(ctl_q, F_LCD)) ||
    (get_f(ctl_q, F_BUS) == get_f(ctl_q, F_PER)));

  // R2: spare bits follow the written word
  a_r2_spare_bits: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctl_q[REG_W-1:SPARE_LO] == $past(wr_data[REG_W-1:SPARE_LO])));

  // R8: a refused request leaves the word untouched and is flagged
  a_r8_refuse_holds: assert property (@(posedge clk) disable iff (!rst_n)
    req_refuse |=> ($stable(ctl_q) && reject_q));

  // R9: a write in the same cycle suppresses the reject flag
  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && req_valid) |=> !reject_q);
endmodule

// File: rtl/ckdiv_bank.sv
module ckdiv_bank
  import ckdiv_pkg::*;
#(
  parameter int unsigned SRC_RATE  = 96_000_000,
  parameter int          RATE_W    = 32,
  parameter logic [15:0] RESET_VAL = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [15:0]       wr_data,
  input  logic              req_valid,
  input  logic [2:0]        req_field,
  input  logic [RATE_W-1:0] req_target,
  output logic [15:0]       ctl_rd,
  output logic              req_reject,
  output logic [5:0]        div_tick
);
  logic [2:0]          pick_exp;
  logic [N_FIELDS-1:0] restart;
  ctl_t                ctl_q;

  ckdiv_rate_pick #(.SRC_RATE(SRC_RATE), .RATE_W(RATE_W)) u_pick (
    .target_i (req_target),
    .exp_o    (pick_exp)
  );

  ckdiv_ctlreg #(.RESET_VAL(RESET_VAL)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .req_valid (req_valid),
    .req_field (req_field),
    .req_exp   (pick_exp),
    .ctl_q     (ctl_q),
    .reject_q  (req_reject),
    .restart_o (restart)
  );

  for (genvar g = 0; g < N_FIELDS; g++) begin : g_div
    ckdiv_strobe u_strobe (
      .clk       (clk),
      .rst_n     (rst_n),
      .exp_i     (get_f(ctl_q, g)),
      .restart_i (restart[g]),
      .tick_o    (div_tick[g])
    );
  end

  assign ctl_rd = ctl_q;
endmodule

// File: tb/ckdiv_bank_test.sv
module ckdiv_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam longint SRC = 96_000_000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_field = '0;
  logic [31:0] req_target = '0;
  logic [15:0] ctl_rd;
  logic        req_reject;
  logic [5:0]  div_tick;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit cmp_on = 0;
  string cur_req = "R1";

  // behavioural model state
  logic [15:0] m_word;
  int          m_phase[6];
  bit          m_rej;

  ckdiv_bank #(.SRC_RATE(96_000_000), .RATE_W(32), .RESET_VAL(16'h0000)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .req_valid(req_valid), .req_field(req_field), .req_target(req_target),
    .ctl_rd(ctl_rd), .req_reject(req_reject), .div_tick(div_tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int fld(logic [15:0] v, int i);
    return int'((v >> (2*i)) & 16'h3);
  endfunction

  function automatic logic [15:0] m_legal(logic [15:0] v);
    int f[6];
    int lo, hi;
    logic [15:0] r;
    for (int i = 0; i < 6; i++) f[i] = fld(v, i);
    if (f[2] < f[1]) f[2] = f[1];
    if (f[2] > f[1] + 1) f[2] = f[1] + 1;
    lo = (f[0] > f[2]) ? f[0] : f[2];
    if (f[3] < lo) f[3] = lo;
    hi = (f[4] < f[5]) ? f[4] : f[5];
    if (f[3] > hi) f[3] = hi;
    r = v & 16'hF000;
    for (int i = 0; i < 6; i++) r = r | 16'(f[i] << (2*i));
    return r;
  endfunction

  function automatic int m_pick(longint t);
    for (int e = 0; e < 4; e++) if (SRC / (64'd1 << e) <= t) return e;
    return 4;
  endfunction

  always @(posedge clk) begin
    logic [15:0] nw;
    bit rj;
    int e;
    if (!rst_n) begin
      m_word = m_legal(16'h0000);
      for (int i = 0; i < 6; i++) m_phase[i] = 0;
      m_rej = 0;
    end else begin
      nw = m_word;
      rj = 0;
      if (wr_en) nw = m_legal(wr_data);
      else if (req_valid) begin
        e = m_pick(longint'(req_target));
        if (req_field > 3'd5 || e == 4) rj = 1;
        else begin
          nw = m_word & ~(16'h3 << (2*req_field));
          nw = nw | 16'(e << (2*req_field));
          nw = m_legal(nw);
        end
      end
      for (int i = 0; i < 6; i++) begin
        if (fld(nw, i) != fld(m_word, i)) m_phase[i] = 0;
        else m_phase[i] = (m_phase[i] + 1) % (1 << fld(m_word, i));
      end
      m_word = nw;
      m_rej = rj;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      logic [5:0] et;
      for (int i = 0; i < 6; i++) et[i] = (m_phase[i] == 0);
      checks++;
      if (ctl_rd !== m_word) begin
        failures++;
        $display("FAIL %s word act=%h exp=%h t=%0t", cur_req, ctl_rd, m_word, $time);
      end
      checks++;
      if (div_tick !== et) begin
        failures++;
        $display("FAIL %s ticks act=%b exp=%b t=%0t", cur_req, div_tick, et, $time);
      end
      checks++;
      if (req_reject !== m_rej) begin
        failures++;
        $display("FAIL %s reject act=%b exp=%b t=%0t", cur_req, req_reject, m_rej, $time);
      end
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(logic [15:0] v);
    @(negedge clk);
    wr_en = 1; wr_data = v;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic do_req(logic [2:0] f, logic [31:0] t);
    @(negedge clk);
    req_valid = 1; req_field = f; req_target = t;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    cmp_on = 1;
    // R1: reset state
    cur_req = "R1";
    @(negedge clk);
    chk("R1 word", ctl_rd, 16'h0000);
    chk("R1 ticks", {10'h0, div_tick}, 16'h003F);
    idle(3);

    // R2: spare bits pass, fields at their positions
    cur_req = "R2";
    do_write(16'hF000);
    chk("R2 spare", ctl_rd, 16'hF000);

    // R3/R4: MMU raised to DSP, bus raised to max(CPU,MMU)
    cur_req = "R3";
    do_write(16'hAF09);
    chk("R3 mmu raise", ctl_rd, 16'hAFA9);
    do_write(16'h0F30);
    chk("R3 mmu lower", ctl_rd, 16'h0F50);
    cur_req = "R4";
    chk("R4 bus floor", {14'h0, ctl_rd[7:6]}, 16'h0001);

    // R5: ceiling wins over floor
    cur_req = "R5";
    do_write(16'h0903);
    chk("R5 bus ceiling", ctl_rd, 16'h0943);

    // R6: CPU divide by 4, pulse pattern 1,0,0,0,1
    cur_req = "R6";
    do_write(16'h0F82);
    chk("R6 tick0 c0", {15'h0, div_tick[0]}, 16'h1);
    idle(1); chk("R6 tick0 c1", {15'h0, div_tick[0]}, 16'h0);
    idle(1); chk("R6 tick0 c2", {15'h0, div_tick[0]}, 16'h0);
    idle(1); chk("R6 tick0 c3", {15'h0, div_tick[0]}, 16'h0);
    idle(1); chk("R6 tick0 c4", {15'h0, div_tick[0]}, 16'h1);

    // R10: rewriting the same value keeps phase (phase now 1 after write)
    cur_req = "R10";
    do_write(16'h0F82);
    chk("R10 no restart", {15'h0, div_tick[0]}, 16'h0);
    idle(6);

    // R7: rate requests
    cur_req = "R7";
    do_write(16'h0F00);
    do_req(3'd0, 32'd30_000_000);
    chk("R7 pick 2", ctl_rd, 16'h0F82);
    chk("R7 no reject", {15'h0, req_reject}, 16'h0);
    do_req(3'd5, 32'd96_000_000);
    chk("R7 per fast", ctl_rd, 16'h0302);

    // R8: rejections
    cur_req = "R8";
    do_req(3'd0, 32'd10_000_000);
    chk("R8 too slow word", ctl_rd, 16'h0302);
    chk("R8 too slow flag", {15'h0, req_reject}, 16'h1);
    do_req(3'd6, 32'd96_000_000);
    chk("R8 bad field word", ctl_rd, 16'h0302);
    chk("R8 bad field flag", {15'h0, req_reject}, 16'h1);
    idle(1);
    chk("R8 flag clears", {15'h0, req_reject}, 16'h0);

    // R9: write and request together
    cur_req = "R9";
    @(negedge clk);
    wr_en = 1; wr_data = 16'h5000;
    req_valid = 1; req_field = 3'd0; req_target = 32'd1;
    @(negedge clk);
    wr_en = 0; req_valid = 0;
    chk("R9 write stored", ctl_rd, 16'h5000);
    chk("R9 no reject", {15'h0, req_reject}, 16'h0);

    // mixed traffic against the model
    cur_req = "R2";
    for (int k = 0; k < 300; k++) begin
      if ($urandom_range(0, 1) == 0) do_write(16'($urandom));
      else begin
        case ($urandom_range(0, 4))
          0: do_req(3'($urandom_range(0, 7)), 32'd96_000_000);
          1: do_req(3'($urandom_range(0, 7)), 32'd50_000_000);
          2: do_req(3'($urandom_range(0, 7)), 32'd24_000_000);
          3: do_req(3'($urandom_range(0, 7)), 32'd12_000_000);
          default: do_req(3'($urandom_range(0, 7)), 32'd11_999_999);
        endcase
      end
      idle($urandom_range(0, 9));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule